// File: doc/BRIEF.md
# Privileged status register write unit

This block holds the 32-bit processor status control word and applies software writes to it. Each write passes through a writable-bit mask. When the newer-revision flag is set, further filters apply, and they depend on the value being written. A reserved privilege-mode code is refused. The soft-reset and NMI indicators can be cleared but never set. The kernel, supervisor and user segment enables are chained so that a lower segment cannot stay enabled once a higher one is disabled.

When any segment enable that was set is changed by a write, the block raises a one-cycle request to flush the address translation buffer. Every write also copies the usable, MX and privilege fields, together with the current 8-bit address-space ID, into the status mirror word of the selected thread context. The other mirror words are left as they are.

Top module: `status_wr_unit`

## Requirements
- R1: After reset the status word is 32'h0000_0000, with soft-reset (bit 20) clear and privilege mode (bits 4:3) = 00 (kernel). All mirror words are zero and the flush output is low.
- R2: A write updates only the bits set in WR_MASK (default 32'hF118_00F9). The result is new = (old & ~WR_MASK) | (data & WR_MASK). In old-revision mode, writing 32'hFFFF_FFFF to a cleared word yields 32'hF118_00F9.
- R3: In newer-revision mode (rev_new = 1), when both privilege bits 4:3 are in WR_MASK and the written value of bits 4:3 is 3, bits 4:3 keep their previous value. The other bits of that write still apply.
- R4: In newer-revision mode, a 1 written to soft-reset (bit 20) or NMI (bit 19) leaves that bit unchanged, and a 0 written there clears it. In old-revision mode both bits are written normally.
- R5: In newer-revision mode with WIDE64 = 1, the segment enables KX (bit 7), SX (bit 6) and UX (bit 5) are chained. A written KX of 0 forces SX to 0, and a resulting SX of 0 forces UX to 0.
- R6: In old-revision mode, the segment enables are written as given, with no chaining.
- R7: When a write changes any of bits 7:5 that was 1 before the write, flush_o is high for exactly the one cycle in which the new status value first appears. A write that only sets segment bits, or that leaves them unchanged, does not raise flush_o.
- R8: Each write sets four fields of mirror word ctx_sel to the new status value: bits 31:28 take usable (status 31:28), bit 27 takes MX (status 24), bits 12:11 take privilege (status 4:3), and bits 7:0 take asid_in. Mirror words of the other contexts are unchanged.
- R9: While wr_en is low, the status word and all mirror words hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value written to the status word |
| rev_new | input | 1 | 1 selects newer-revision write filtering |
| ctx_sel | input | 2 | Thread context whose mirror is updated |
| asid_in | input | 8 | Current address-space ID |
| status_q | output | 32 | Status word |
| mirror_q | output | 128 | Mirror words, context n at bits 32n+31:32n |
| flush_o | output | 1 | One-cycle translation flush request |

## Verification
Three effects can fall on the same write: the loss of a segment enable raises the flush pulse, the chaining rule produces that loss, and the selected context's mirror word is updated. The bench provokes all three with one newer-revision write of KX = 0, SX = 1, UX = 1 to a word holding all three enables, sent to context 3. In the cycle after that write it checks three things together: the status value with all enables cleared, flush_o high, and mirror word 3 carrying the new fields. It also checks that the other mirror words are unchanged and that flush_o falls in the following cycle.

// File: rtl/status_wr_unit.sv
module status_wr_unit #(
  parameter logic [31:0] WR_MASK = 32'hF118_00F9,
  parameter logic [31:0] RST_VAL = 32'h0000_0000,
  parameter int          NCTX    = 4,
  parameter bit          WIDE64  = 1'b1,
  parameter bit          MT_EN   = 1'b1,
  localparam int         CTXW    = $clog2(NCTX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  input  logic                 rev_new,
  input  logic [CTXW-1:0]      ctx_sel,
  input  logic [7:0]           asid_in,
  output logic [31:0]          status_q,
  output logic [NCTX*32-1:0]   mirror_q,
  output logic                 flush_o
);

  localparam logic [31:0] SEG_MSK = 32'h0000_00E0;
  localparam logic [31:0] PRV_MSK = 32'h0000_0018;
  localparam logic [31:0] STK_MSK = 32'h0018_0000;
  localparam logic [31:0] MIR_MSK = 32'hF800_18FF;
  localparam logic [31:0] RST_EFF = RST_VAL & ~(32'h0010_0000 | PRV_MSK);

  logic        kx_c, sx_c, ux_c;
  logic [31:0] data_f, mask_f, nxt;

  assign kx_c = wr_data[7];
  assign sx_c = wr_data[6] & kx_c;
  assign ux_c = wr_data[5] & sx_c;

  assign data_f = (rev_new && WIDE64) ? {wr_data[31:8], kx_c, sx_c, ux_c, wr_data[4:0]}
                                      : wr_data;

  always_comb begin
    mask_f = WR_MASK;
    if (rev_new) begin
      if ((WR_MASK[4:3] == 2'b11) && (wr_data[4:3] == 2'b11))
        mask_f = mask_f & ~PRV_MSK;
      mask_f = mask_f & ~(STK_MSK & wr_data);
    end
  end

  assign nxt = (status_q & ~mask_f) | (data_f & mask_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= RST_EFF;
      flush_o  <= 1'b0;
    end else begin
      flush_o <= WIDE64 && wr_en && (|((nxt ^ status_q) & status_q & SEG_MSK));
      if (wr_en) status_q <= nxt;
    end
  end

  logic [31:0] mir_new;
  assign mir_new = {nxt[31:28], nxt[24], 14'd0, nxt[4:3], 3'd0, asid_in};

  for (genvar g = 0; g < NCTX; g++) begin : g_mir
    always_ff @(posedge clk) begin
      if (!rst_n)
        mirror_q[g*32 +: 32] <= 32'd0;
      else if (MT_EN && wr_en && (ctx_sel == CTXW'(g)))
        mirror_q[g*32 +: 32] <= (mirror_q[g*32 +: 32] & ~MIR_MSK) | (mir_new & MIR_MSK);
    end
  end

endmodule

// File: rtl/status_wr_unit_chk.sv
module status_wr_unit_chk #(
  parameter logic [31:0] WR_MASK = 32'hF118_00F9,
  parameter int          NCTX    = 4,
  parameter bit          WIDE64  = 1'b1,
  parameter bit          MT_EN   = 1'b1,
  localparam int         CTXW    = $clog2(NCTX)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic               rev_new,
  input logic [CTXW-1:0]    ctx_sel,
  input logic [7:0]         asid_in,
  input logic [31:0]        status_q,
  input logic [NCTX*32-1:0] mirror_q,
  input logic               flush_o
);

  localparam bit PRV_FULL = (WR_MASK[4:3] == 2'b11);
  localparam bit SEG_FULL = (WR_MASK[7:5] == 3'b111);

  logic [CTXW-1:0] ctx_d;
  always_ff @(posedge clk) ctx_d <= ctx_sel;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status_q) && $stable(mirror_q));

  a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(wr_en) && (|((status_q ^ $past(status_q)) & $past(status_q) & 32'hE0)));

  a_r4_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_new && wr_en) |=> !(status_q[20] && !$past(status_q[20])) &&
                           !(status_q[19] && !$past(status_q[19])));

  a_r3_priv_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (PRV_FULL && rev_new && wr_en && wr_data[4:3] == 2'b11) |=> $stable(status_q[4:3]));

  a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE64 && SEG_FULL && rev_new && wr_en) |=>
      (!status_q[6] || status_q[7]) && (!status_q[5] || status_q[6]));

  a_r8_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (MT_EN && wr_en) |=> mirror_q[ctx_d*32 +: 8] == $past(asid_in) &&
                         mirror_q[ctx_d*32+28 +: 4] == status_q[31:28] &&
                         mirror_q[ctx_d*32+11 +: 2] == status_q[4:3]);

endmodule

bind status_wr_unit status_wr_unit_chk #(
  .WR_MASK(WR_MASK), .NCTX(NCTX), .WIDE64(WIDE64), .MT_EN(MT_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rev_new(rev_new),
  .ctx_sel(ctx_sel), .asid_in(asid_in), .status_q(status_q), .mirror_q(mirror_q),
  .flush_o(flush_o)
);

// File: tb/status_wr_unit_bench.sv
module status_wr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic         rev_new = 1'b0;
  logic [1:0]   ctx_sel = '0;
  logic [7:0]   asid_in = '0;
  logic [31:0]  status_q;
  logic [127:0] mirror_q;
  logic         flush_o;

  int checks = 0;
  int failures = 0;
  logic flush_seen;

  status_wr_unit u_status_wr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rev_new(rev_new),
    .ctx_sel(ctx_sel), .asid_in(asid_in), .status_q(status_q), .mirror_q(mirror_q),
    .flush_o(flush_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic rv, input logic [1:0] c, input logic [7:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; rev_new = rv; ctx_sel = c; asid_in = a;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'hA5A5_A5A5;
    flush_seen = flush_o;
  endtask

  task automatic t_reset;
    chk("R1 status", status_q, 32'h0);
    chk("R1 mirrors", {31'd0, |mirror_q}, 32'h0);
    chk("R1 flush", {31'd0, flush_o}, 32'h0);
  endtask

  task automatic t_mask;
    wr(32'hFFFF_FFFF, 1'b0, 2'd0, 8'h5A);
    chk("R2 masked write", status_q, 32'hF118_00F9);
    chk("R7 no flush on set", {31'd0, flush_seen}, 32'h0);
    chk("R8 mirror0", mirror_q[31:0], 32'hF800_185A);
  endtask

  task automatic t_hold;
    @(negedge clk); wr_data = 32'h0;
    @(negedge clk); @(negedge clk);
    chk("R9 hold status", status_q, 32'hF118_00F9);
    chk("R9 hold mirror0", mirror_q[31:0], 32'hF800_185A);
  endtask

  task automatic t_flush;
    wr(32'h0, 1'b0, 2'd1, 8'h33);
    chk("R7 status cleared", status_q, 32'h0);
    chk("R7 flush high", {31'd0, flush_seen}, 32'h1);
    chk("R8 mirror1", mirror_q[63:32], 32'h0000_0033);
    chk("R8 mirror0 untouched", mirror_q[31:0], 32'hF800_185A);
    @(negedge clk);
    chk("R7 flush one cycle", {31'd0, flush_o}, 32'h0);
  endtask

  task automatic t_priv;
    wr(32'h0000_0008, 1'b1, 2'd2, 8'h00);
    chk("R3 priv 01 accepted", status_q, 32'h0000_0008);
    wr(32'h0000_0019, 1'b1, 2'd2, 8'h00);
    chk("R3 priv 3 refused", status_q, 32'h0000_0009);
    chk("R8 mirror2 priv", mirror_q[95:64], 32'h0000_0800);
    wr(32'h0000_0018, 1'b0, 2'd2, 8'h00);
    chk("R3 old rev allows 3", status_q, 32'h0000_0018);
  endtask

  task automatic t_srnmi;
    wr(32'h0018_0000, 1'b0, 2'd2, 8'h00);
    chk("R4 old rev sets", status_q, 32'h0018_0000);
    wr(32'h0018_0001, 1'b1, 2'd2, 8'h00);
    chk("R4 ones keep", status_q, 32'h0018_0001);
    wr(32'h0000_0000, 1'b1, 2'd2, 8'h00);
    chk("R4 zero clears", status_q, 32'h0);
    wr(32'h0010_0000, 1'b1, 2'd2, 8'h00);
    chk("R4 cannot set", status_q, 32'h0);
  endtask

  task automatic t_chain;
    wr(32'h0000_0060, 1'b1, 2'd2, 8'h00);
    chk("R5 KX0 clears SX UX", status_q, 32'h0);
    wr(32'h0000_00A0, 1'b1, 2'd2, 8'h00);
    chk("R5 SX0 clears UX", status_q, 32'h0000_0080);
    wr(32'h0000_00E0, 1'b1, 2'd2, 8'h00);
    chk("R5 all enabled", status_q, 32'h0000_00E0);
    chk("R7 no flush when kept", {31'd0, flush_seen}, 32'h0);
  endtask

  task automatic t_chain_flush;
    wr(32'h0000_0060, 1'b1, 2'd3, 8'hC4);
    chk("R5 chain drop", status_q, 32'h0);
    chk("R7 flush with chain", {31'd0, flush_seen}, 32'h1);
    chk("R8 mirror3", mirror_q[127:96], 32'h0000_00C4);
    chk("R8 mirror1 untouched", mirror_q[63:32], 32'h0000_0033);
    @(negedge clk);
    chk("R7 flush falls", {31'd0, flush_o}, 32'h0);
  endtask

  task automatic t_oldrev;
    wr(32'h0000_0060, 1'b0, 2'd3, 8'hC4);
    chk("R6 no chaining", status_q, 32'h0000_0060);
    chk("R7 no flush", {31'd0, flush_seen}, 32'h0);
    wr(32'h0000_0040, 1'b0, 2'd3, 8'hC4);
    chk("R6 UX dropped", status_q, 32'h0000_0040);
    chk("R7 flush on UX loss", {31'd0, flush_seen}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_hold;
    t_flush;
    t_priv;
    t_srnmi;
    t_chain;
    t_chain_flush;
    t_oldrev;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule